// File: doc/BRIEF.md
# Pixel Clock Divider Parameter Search

This block chooses the three integer settings of a display clock chain: a PLL multiplier `m`, a predivider `n` and a post-divider `d`. The aim is that a fixed reference frequency, multiplied by `m`, divided by `n` and then divided by `d`, comes as close as possible to a requested pixel rate. A controller pulses `start_i` with the target rate on `rate_i`. The engine then walks a fixed nested candidate space, and every division goes through one shared restoring divider. It keeps the best candidate found so far and raises `done_o` when it finishes. The chosen triple, the rate it gives and an error flag are held until the next accepted start.

The reference frequency and the oscillator ceiling are parameters, and so are the candidate limits and the datapath widths. The post-divider is also placed into a 32-bit control-word image at bits 15:8, ready to be written into a display controller's clock divisor field. The block does not program the PLL and does not watch for lock.

Top module: `pixclk_div_search`

## Requirements
- R1: After reset `busy_o`, `done_o` and `err_o` are all low.
- R2: A `start_i` pulse seen while idle captures `rate_i`, and `busy_o` is high one cycle later. A `start_i` pulse seen while busy is ignored, so the result is the one for the rate captured first.
- R3: A rate of zero, or a rate above `VCO_MAX_HZ/2`, is rejected without any search. In this case `done_o` and `err_o` are high one cycle after the start and `busy_o` never rises.
- R4: Candidates are visited with `d` as the outer loop, from 2 up to `D_LAST`, and `m` as the inner loop, from 2 up to `M_LAST`. A candidate with `REF_HZ*m < rate*d` is skipped. Otherwise the predivider is `n = floor(REF_HZ*m / (rate*d))`.
- R5: The inner loop is left for the next `d` when `n > N_MAX`, or when `floor(REF_HZ*m/n) > VCO_MAX_HZ`.
- R6: A candidate's rate is `floor(floor(REF_HZ*m/n)/d)`, and its error is the absolute difference from the target. A candidate is recorded only when its error is strictly below the best error so far, so ties keep the earlier candidate. The best error starts equal to the target.
- R7: The first candidate with zero error is reported and ends the whole search at once.
- R8: If no candidate is ever recorded, the search ends with `done_o` and `err_o` both high. `err_o` is never high without `done_o`.
- R9: `ctrl_div_o` carries the chosen post-divider in bits 15:8, and every other bit of it is zero.
- R10: `busy_o` and `done_o` are never high together. While done, the reported values stay stable until the next accepted start, whatever happens on `rate_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; it captures `rate_i` when the block is idle |
| rate_i | input | RATE_W | Requested pixel rate in Hz |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | The result is valid; held until the next accepted start |
| err_o | output | 1 | The rate was rejected or no candidate was found |
| best_m_o | output | clog2(M_LAST+1) | Chosen multiplier |
| best_n_o | output | clog2(N_MAX+1) | Chosen predivider |
| best_d_o | output | clog2(D_LAST+1) | Chosen post-divider |
| rate_o | output | RATE_W | Rate produced by the chosen triple |
| ctrl_div_o | output | 32 | Control-word image with the post-divider in bits 15:8 |

## Verification
The hardest cases to reach from the ports are ties and late improvements deep inside the nested walk, together with a search that ends with nothing recorded. Both depend on how the candidate arithmetic plays out over many `(d, m)` pairs. The bench therefore runs the block with a small reference, a small ceiling and small loop limits, so that whole searches finish quickly. Random rates are compared against a bench model of the walk. Directed rates are added for an exact hit on the first candidate, a rate at the ceiling boundary where every candidate overshoots the oscillator limit, and a second start pulse sent mid-search.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CAND,
    S_WAIT_N,
    S_WAIT_V,
    S_WAIT_R,
    S_NEXT_D,
    S_FIN
  } pxs_state_e;
endpackage

// File: rtl/pxs_divider.sv
module pxs_divider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         vld_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic          act_q, act_d;
  logic          vld_q, vld_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;
  logic          fits;

  // one restoring step per cycle: shift in the next dividend bit, try to subtract
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~trial[W+1] & ~trial[W];
    act_d   = act_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    vld_d   = 1'b0;
    if (go_i) begin
      act_d = 1'b1;
      cnt_d = CW'(W);
      rem_d = '0;
      quo_d = num_i;
      dvs_d = den_i;
    end else if (act_q) begin
      if (fits) begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        act_d = 1'b0;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      vld_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else begin
      act_q <= act_d;
      vld_q <= vld_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  assign vld_o = vld_q;
  assign quo_o = quo_q;
endmodule

// File: rtl/pxs_err_cmp.sv
module pxs_err_cmp #(
  parameter int W = 40
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] tgt_i,
  input  logic [W-1:0] best_i,
  output logic [W-1:0] err_o,
  output logic         better_o,
  output logic         exact_o
);
  always_comb begin
    err_o    = (cand_i > tgt_i) ? (cand_i - tgt_i) : (tgt_i - cand_i);
    better_o = err_o < best_i;
    exact_o  = (err_o == '0);
  end
endmodule

// File: rtl/pixclk_div_search.sv
module pixclk_div_search
  import pxs_pkg::*;
#(
  parameter int REF_HZ     = 24_000_000,
  parameter int VCO_MAX_HZ = 200_000_000,
  parameter int RATE_W     = 28,
  parameter int PROD_W     = 40,
  parameter int D_LAST     = 254,
  parameter int M_LAST     = 2046,
  parameter int N_MAX      = 127,
  localparam int M_W = $clog2(M_LAST + 1),
  localparam int N_W = $clog2(N_MAX + 1),
  localparam int D_W = $clog2(D_LAST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [M_W-1:0]    best_m_o,
  output logic [N_W-1:0]    best_n_o,
  output logic [D_W-1:0]    best_d_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [31:0]       ctrl_div_o
);
  localparam int W    = PROD_W;
  localparam int MC_W = $clog2(M_LAST + 2);
  localparam logic [W-1:0] REF_V  = W'(REF_HZ);
  localparam logic [W-1:0] VMAX_V = W'(VCO_MAX_HZ);
  localparam logic [W-1:0] LIM_V  = W'(VCO_MAX_HZ / 2);
  localparam logic [W-1:0] NMAX_V = W'(N_MAX);

  pxs_state_e        st_q, st_d;
  logic [W-1:0]      rate_q, rate_d;
  logic [MC_W-1:0]   m_q, m_d;
  logic [D_W-1:0]    d_q, d_d;
  logic [W-1:0]      num_q, num_d;
  logic [W-1:0]      den_q, den_d;
  logic [N_W-1:0]    n_q, n_d;
  logic [M_W-1:0]    bm_q, bm_d;
  logic [N_W-1:0]    bn_q, bn_d;
  logic [D_W-1:0]    bd_q, bd_d;
  logic [RATE_W-1:0] br_q, br_d;
  logic [W-1:0]      be_q, be_d;
  logic              found_q, found_d;
  logic              done_q, done_d;
  logic              bad_q, bad_d;

  logic              div_go;
  logic [W-1:0]      div_a, div_b;
  logic              div_vld;
  logic [W-1:0]      div_q;
  logic [W-1:0]      cand_err;
  logic              cand_better, cand_exact;

  pxs_divider #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (div_go),
    .num_i (div_a),
    .den_i (div_b),
    .vld_o (div_vld),
    .quo_o (div_q)
  );

  pxs_err_cmp #(.W(W)) u_cmp (
    .cand_i   (div_q),
    .tgt_i    (rate_q),
    .best_i   (be_q),
    .err_o    (cand_err),
    .better_o (cand_better),
    .exact_o  (cand_exact)
  );

  // next-state logic of the nested walk (d outer, m inner)
  always_comb begin
    st_d    = st_q;
    rate_d  = rate_q;
    m_d     = m_q;
    d_d     = d_q;
    num_d   = num_q;
    den_d   = den_q;
    n_d     = n_q;
    bm_d    = bm_q;
    bn_d    = bn_q;
    bd_d    = bd_q;
    br_d    = br_q;
    be_d    = be_q;
    found_d = found_q;
    done_d  = done_q;
    bad_d   = bad_q;
    div_go  = 1'b0;
    div_a   = num_q;
    div_b   = den_q;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          if (rate_i == '0 || W'(rate_i) > LIM_V) begin
            done_d = 1'b1;
            bad_d  = 1'b1;
          end else begin
            rate_d  = W'(rate_i);
            d_d     = D_W'(2);
            den_d   = W'(rate_i) << 1;
            m_d     = MC_W'(2);
            num_d   = REF_V << 1;
            be_d    = W'(rate_i);
            found_d = 1'b0;
            done_d  = 1'b0;
            bad_d   = 1'b0;
            st_d    = S_CAND;
          end
        end
      end
      S_CAND: begin
        if (m_q > MC_W'(M_LAST)) begin
          st_d = S_NEXT_D;
        end else if (num_q < den_q) begin
          m_d   = m_q + MC_W'(1);
          num_d = num_q + REF_V;
        end else begin
          div_go = 1'b1;
          st_d   = S_WAIT_N;
        end
      end
      S_WAIT_N: begin
        if (div_vld) begin
          if (div_q > NMAX_V) begin
            st_d = S_NEXT_D;
          end else begin
            n_d    = N_W'(div_q);
            div_go = 1'b1;
            div_a  = num_q;
            div_b  = div_q;
            st_d   = S_WAIT_V;
          end
        end
      end
      S_WAIT_V: begin
        if (div_vld) begin
          if (div_q > VMAX_V) begin
            st_d = S_NEXT_D;
          end else begin
            div_go = 1'b1;
            div_a  = div_q;
            div_b  = W'(d_q);
            st_d   = S_WAIT_R;
          end
        end
      end
      S_WAIT_R: begin
        if (div_vld) begin
          if (cand_better) begin
            bm_d    = M_W'(m_q);
            bn_d    = n_q;
            bd_d    = d_q;
            br_d    = RATE_W'(div_q);
            be_d    = cand_err;
            found_d = 1'b1;
          end
          if (cand_exact) begin
            st_d = S_FIN;
          end else begin
            m_d   = m_q + MC_W'(1);
            num_d = num_q + REF_V;
            st_d  = S_CAND;
          end
        end
      end
      S_NEXT_D: begin
        if (d_q == D_W'(D_LAST)) begin
          st_d = S_FIN;
        end else begin
          d_d   = d_q + D_W'(1);
          den_d = den_q + rate_q;
          m_d   = MC_W'(2);
          num_d = REF_V << 1;
          st_d  = S_CAND;
        end
      end
      S_FIN: begin
        done_d = 1'b1;
        bad_d  = ~found_q;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rate_q  <= '0;
      m_q     <= '0;
      d_q     <= '0;
      num_q   <= '0;
      den_q   <= '0;
      n_q     <= '0;
      bm_q    <= '0;
      bn_q    <= '0;
      bd_q    <= '0;
      br_q    <= '0;
      be_q    <= '0;
      found_q <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      rate_q  <= rate_d;
      m_q     <= m_d;
      d_q     <= d_d;
      num_q   <= num_d;
      den_q   <= den_d;
      n_q     <= n_d;
      bm_q    <= bm_d;
      bn_q    <= bn_d;
      bd_q    <= bd_d;
      br_q    <= br_d;
      be_q    <= be_d;
      found_q <= found_d;
      done_q  <= done_d;
      bad_q   <= bad_d;
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = bad_q;
  assign best_m_o   = bm_q;
  assign best_n_o   = bn_q;
  assign best_d_o   = bd_q;
  assign rate_o     = br_q;
  assign ctrl_div_o = {16'd0, 8'(bd_q), 8'd0};
endmodule

// File: rtl/pxs_chk.sv
module pxs_chk #(
  parameter int D_LAST = 254,
  parameter int M_LAST = 2046,
  parameter int N_MAX  = 127,
  localparam int M_W = $clog2(M_LAST + 1),
  localparam int N_W = $clog2(N_MAX + 1),
  localparam int D_W = $clog2(D_LAST + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o,
  input logic [M_W-1:0] best_m_o,
  input logic [N_W-1:0] best_n_o,
  input logic [D_W-1:0] best_d_o
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R4
  triple_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (best_m_o >= M_W'(2) && best_m_o <= M_W'(M_LAST)
                            && best_d_o >= D_W'(2) && best_d_o <= D_W'(D_LAST)));

  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (best_n_o >= N_W'(1) && best_n_o <= N_W'(N_MAX)));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> ($stable(best_m_o) && $stable(best_n_o)
                              && $stable(best_d_o) && done_o));

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind pixclk_div_search pxs_chk #(
  .D_LAST (D_LAST),
  .M_LAST (M_LAST),
  .N_MAX  (N_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .best_m_o (best_m_o),
  .best_n_o (best_n_o),
  .best_d_o (best_d_o)
);

// File: tb/pixclk_div_search_tb.sv
`timescale 1ns/1ps
module pixclk_div_search_tb;
  localparam int REF  = 24;
  localparam int VMAX = 200;
  localparam int RW   = 8;
  localparam int PW   = 16;
  localparam int DL   = 10;
  localparam int ML   = 24;
  localparam int NM   = 15;
  localparam int MW   = $clog2(ML + 1);
  localparam int NW   = $clog2(NM + 1);
  localparam int DW   = $clog2(DL + 1);
  localparam int LIMIT = 190000;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [RW-1:0] rate_i;
  logic          busy_o, done_o, err_o;
  logic [MW-1:0] best_m_o;
  logic [NW-1:0] best_n_o;
  logic [DW-1:0] best_d_o;
  logic [RW-1:0] rate_o;
  logic [31:0]   ctrl_div_o;

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  pixclk_div_search #(
    .REF_HZ(REF), .VCO_MAX_HZ(VMAX), .RATE_W(RW), .PROD_W(PW),
    .D_LAST(DL), .M_LAST(ML), .N_MAX(NM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .best_m_o(best_m_o), .best_n_o(best_n_o), .best_d_o(best_d_o),
    .rate_o(rate_o), .ctrl_div_o(ctrl_div_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= LIMIT);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, LIMIT);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model of the nested walk, written from the requirements
  function automatic void model(input int rate, output bit found,
                                output int bm, output int bn, output int bd, output int br);
    longint be, num, den, n, v, c, e;
    bit stop;
    found = 0; bm = 0; bn = 0; bd = 0; br = 0;
    stop = 0;
    be = rate;
    if (rate == 0 || rate > VMAX / 2) return;
    for (int d = 2; d <= DL && !stop; d++) begin
      for (int m = 2; m <= ML; m++) begin
        num = longint'(REF) * m;
        den = longint'(rate) * d;
        if (num < den) continue;
        n = num / den;
        if (n > NM) break;
        v = num / n;
        if (v > VMAX) break;
        c = v / d;
        e = (c > rate) ? c - rate : rate - c;
        if (e < be) begin
          be = e; found = 1; bm = m; bn = int'(n); bd = d; br = int'(c);
          if (e == 0) begin stop = 1; break; end
        end
      end
    end
  endfunction

  task automatic wait_done();
    int k;
    k = 0;
    while (!done_o && k < 40000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic search(input int rate, input int second);
    bit f;
    int bm, bn, bd, br;
    model(rate, f, bm, bn, bd, br);
    @(negedge clk);
    rate_i  = RW'(rate);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "busy after start", longint'(busy_o), 1);
    if (second >= 0) begin
      repeat (4) @(negedge clk);
      rate_i  = RW'(second);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done();
    chk("R10", "done held, busy low", longint'({done_o, busy_o}), 2);
    chk("R8", "error flag", longint'(err_o), longint'(!f));
    if (f) begin
      chk("R4", "multiplier", longint'(best_m_o), bm);
      chk("R4", "post-divider", longint'(best_d_o), bd);
      chk("R5", "predivider", longint'(best_n_o), bn);
      chk("R6", "rounded rate", longint'(rate_o), br);
      chk("R9", "control word", longint'(ctrl_div_o), longint'(bd) << 8);
    end
  endtask

  task automatic reject(input int rate);
    @(negedge clk);
    rate_i  = RW'(rate);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R3", "reject done/err/busy", longint'({done_o, err_o, busy_o}), 6);
    @(negedge clk);
    chk("R3", "no search started", longint'(busy_o), 0);
  endtask

  initial begin
    int unsigned s;
    int r;
    logic [MW-1:0] hm;
    logic [DW-1:0] hd;
    logic [RW-1:0] hr;
    s = $urandom(32'd4711);
    rst_n   = 1'b0;
    start_i = 1'b0;
    rate_i  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset busy/done/err", longint'({busy_o, done_o, err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", longint'({busy_o, done_o, err_o}), 0);

    // R7 exact hit on the very first candidate: m=2 n=2 d=2 rate 12
    search(12, -1);
    chk("R7", "exact triple", longint'({best_m_o, best_n_o, best_d_o}),
        longint'({MW'(2), NW'(2), DW'(2)}));
    chk("R7", "exact rate", longint'(rate_o), 12);

    // R10 outputs held while rate_i wanders and no start arrives
    hm = best_m_o; hd = best_d_o; hr = rate_o;
    rate_i = RW'(77);
    repeat (12) @(negedge clk);
    chk("R10", "held m", longint'(best_m_o), longint'(hm));
    chk("R10", "held d", longint'(best_d_o), longint'(hd));
    chk("R10", "held rate", longint'(rate_o), longint'(hr));

    // R3 rejected rates
    reject(0);
    reject(VMAX / 2 + 1);
    reject(255);

    // R8 boundary rate: every candidate exceeds the oscillator ceiling
    search(VMAX / 2, -1);
    chk("R8", "ceiling rate errors", longint'(err_o), 1);

    // R2 start during a search is ignored: result must be for 12, not 50
    search(12, 50);
    chk("R2", "ignored second start", longint'({best_m_o, best_n_o, best_d_o}),
        longint'({MW'(2), NW'(2), DW'(2)}));

    // directed values then random ones (R4 R5 R6)
    search(1, -1);
    search(7, -1);
    for (int i = 0; i < 6; i++) begin
      r = int'($urandom_range(2, 60));
      search(r, -1);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule